// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

The block is a watchdog timer that a processor services through a small synchronous register bus: a word address, 16-bit write data, a write strobe and combinational read data. It is never configured by plain register writes alone. Every control action goes through 16-bit magic values written to a key register. One key starts the watchdog, one refreshes it, and a pair of keys opens and closes write access to the divider and reload registers.

While running, a power-of-two divider turns the system clock into counter ticks. A 12-bit down-counter is decremented on each tick. When the counter is already at zero on a tick, the block emits a one-cycle reset request and starts over from the reload value.

New divider and reload values do not reach the counter at once. Each accepted write raises a per-register update flag in the status register. The new value is applied only when that flag drops after a fixed delay. Software polls the flags to learn when its settings are in force. Once started, the watchdog keeps running until the system reset.

Top module: `kwdg_top`

## Requirements
- R1: After reset, `rst_req` is low, the watchdog is not running, the status register (offset 0x0C) reads 0, the divider register (offset 0x04) reads 0 and the reload register (offset 0x08) reads 0xFFF.
- R2: Before the start key 0xCCCC is written to offset 0x00, no reset request is ever raised. Writing it loads the counter from the active reload value and starts counting.
- R3: With active reload value R and divider field N (bits [3:0] of offset 0x04; values above 8 act as 8), the first reset request after a start or refresh comes exactly (R+1)·2^(N+2) clock cycles after the write edge.
- R4: Writing the refresh key 0xAAAA to offset 0x00 reloads the counter and restarts the divider, so the next request is a full timeout after that write.
- R5: Writing 0x5555 to offset 0x00 opens configuration access and writing 0x0000 closes it; it is closed after reset. While closed, writes to offsets 0x04 and 0x08 change neither the readback nor the status.
- R6: An accepted divider write sets status bit 0, and an accepted reload write (bits [11:0] of offset 0x08) sets status bit 1. Each flag reads 1 for exactly 4 clock cycles after the write edge, and the new value takes effect when the flag clears.
- R7: The reset request is a single-cycle pulse. The counter then reloads by itself, so while the watchdog is not refreshed, requests repeat with the R3 period.
- R8: Once started, no register write stops the watchdog. Only the system reset returns it to idle.
- R9: A write to offset 0x00 of any value other than the four keys has no effect: it neither refreshes the counter nor changes the access state.
- R10: Offsets 0x00 and 0x10 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of counter ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong divider or counter state shows up only as a reset request that comes early, late or never. The bench therefore times each request to the exact cycle over every divider setting and two reload values. A stuck or mis-timed update flag is visible on the status register within its four-cycle window. A wrong access or running state shows up only on later writes, so each lock, key and stop attempt is followed by a readback or a timed expiry before the next stimulus.

// File: rtl/kwdg_pkg.sv
package kwdg_pkg;

  localparam int REG_AW = 5;
  localparam int KEY_W  = 16;

  localparam logic [REG_AW-1:0] OFS_KEY = 5'h00;
  localparam logic [REG_AW-1:0] OFS_PRE = 5'h04;
  localparam logic [REG_AW-1:0] OFS_RLD = 5'h08;
  localparam logic [REG_AW-1:0] OFS_STS = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_WIN = 5'h10;

  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_SHUT  = 16'h0000;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_START,
    CMD_FEED,
    CMD_OPEN,
    CMD_SHUT
  } key_cmd_e;

  function automatic key_cmd_e decode_key(input logic [KEY_W-1:0] k);
    case (k)
      KEY_START: return CMD_START;
      KEY_FEED:  return CMD_FEED;
      KEY_OPEN:  return CMD_OPEN;
      KEY_SHUT:  return CMD_SHUT;
      default:   return CMD_NONE;
    endcase
  endfunction

  // Terminal count of the divider: 2^(min(field,max_field)+2) - 1.
  function automatic int unsigned pre_limit(input int unsigned field,
                                            input int unsigned max_field);
    int unsigned f;
    f = (field > max_field) ? max_field : field;
    return (32'd1 << (f + 2)) - 1;
  endfunction

endpackage

// File: rtl/kwdg_keydec.sv
module kwdg_keydec
  import kwdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [KEY_W-1:0]  wdata,
  output logic              start_ev,
  output logic              feed_ev,
  output logic              running,
  output logic              unlocked,
  output logic              pre_wr,
  output logic              rld_wr
);

  key_cmd_e cmd;

  always_comb begin
    cmd = CMD_NONE;
    if (we && addr == OFS_KEY) cmd = decode_key(wdata);
  end

  assign start_ev = (cmd == CMD_START);
  assign feed_ev  = (cmd == CMD_FEED);
  assign pre_wr   = we && (addr == OFS_PRE) && unlocked;
  assign rld_wr   = we && (addr == OFS_RLD) && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (cmd == CMD_START) running <= 1'b1;
      if (cmd == CMD_OPEN)       unlocked <= 1'b1;
      else if (cmd == CMD_SHUT)  unlocked <= 1'b0;
    end
  end

endmodule

// File: rtl/kwdg_cfgreg.sv
module kwdg_cfgreg #(
  parameter int          W     = 12,
  parameter logic [W-1:0] RST  = '0,
  parameter int          LAT   = 4,
  localparam int         LAT_W = $clog2(LAT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] staged,
  output logic [W-1:0] active,
  output logic         pend
);

  logic [LAT_W-1:0] dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= RST;
      active <= RST;
      pend   <= 1'b0;
      dly    <= '0;
    end else if (wr) begin
      staged <= din;
      pend   <= 1'b1;
      dly    <= LAT_W'(LAT);
    end else if (pend) begin
      if (dly == LAT_W'(1)) begin
        pend   <= 1'b0;
        active <= staged;
      end else begin
        dly <= dly - 1'b1;
      end
    end
  end

endmodule

// File: rtl/kwdg_prescaler.sv
module kwdg_prescaler
  import kwdg_pkg::*;
#(
  parameter int FW   = 4,
  parameter int MAXF = 8,
  localparam int PCW = MAXF + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          restart,
  input  logic [FW-1:0] field,
  output logic          tick
);

  logic [PCW-1:0] pre_cnt;
  logic [PCW-1:0] limit;

  assign limit = PCW'(pre_limit(32'(field), MAXF));
  assign tick  = running && (pre_cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)               pre_cnt <= '0;
    else if (restart || tick) pre_cnt <= '0;
    else if (running)         pre_cnt <= pre_cnt + 1'b1;
  end

endmodule

// File: rtl/kwdg_downcnt.sv
module kwdg_downcnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] reload_val,
  output logic          zero,
  output logic          req
);

  logic [CW-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '1;
      req <= 1'b0;
    end else begin
      req <= 1'b0;
      if (load) begin
        cnt <= reload_val;
      end else if (tick) begin
        if (zero) begin
          cnt <= reload_val;
          req <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/kwdg_top.sv
module kwdg_top
  import kwdg_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int PRE_FW   = 4,
  parameter int PRE_MAX  = 8,
  parameter int SYNC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [KEY_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [KEY_W-1:0]  bus_rdata,
  output logic              rst_req
);

  localparam logic [CNT_W-1:0]  RLD_RST = '1;
  localparam logic [PRE_FW-1:0] PRE_RST = '0;

  logic              start_ev, feed_ev, running_w, unlocked_w;
  logic              pre_wr, rld_wr, pvu, rvu, tick_w, cnt_zero, load_ev;
  logic [PRE_FW-1:0] pre_staged, pre_active;
  logic [CNT_W-1:0]  rld_staged, rld_active;

  assign load_ev = start_ev || feed_ev;

  kwdg_keydec u_key (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .start_ev(start_ev), .feed_ev(feed_ev), .running(running_w),
    .unlocked(unlocked_w), .pre_wr(pre_wr), .rld_wr(rld_wr)
  );

  kwdg_cfgreg #(.W(PRE_FW), .RST(PRE_RST), .LAT(SYNC_LAT)) u_pre_reg (
    .clk(clk), .rst_n(rst_n), .wr(pre_wr), .din(bus_wdata[PRE_FW-1:0]),
    .staged(pre_staged), .active(pre_active), .pend(pvu)
  );

  kwdg_cfgreg #(.W(CNT_W), .RST(RLD_RST), .LAT(SYNC_LAT)) u_rld_reg (
    .clk(clk), .rst_n(rst_n), .wr(rld_wr), .din(bus_wdata[CNT_W-1:0]),
    .staged(rld_staged), .active(rld_active), .pend(rvu)
  );

  kwdg_prescaler #(.FW(PRE_FW), .MAXF(PRE_MAX)) u_pre (
    .clk(clk), .rst_n(rst_n), .running(running_w), .restart(load_ev),
    .field(pre_active), .tick(tick_w)
  );

  kwdg_downcnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .load(load_ev),
    .reload_val(rld_active), .zero(cnt_zero), .req(rst_req)
  );

  always_comb begin
    case (bus_addr)
      OFS_PRE: bus_rdata = KEY_W'(pre_staged);
      OFS_RLD: bus_rdata = KEY_W'(rld_staged);
      OFS_STS: bus_rdata = KEY_W'({rvu, pvu});
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/kwdg_chk.sv
module kwdg_chk (
  input logic clk,
  input logic rst_n,
  input logic running,
  input logic unlocked,
  input logic pvu,
  input logic rvu,
  input logic pre_wr,
  input logic rld_wr,
  input logic tick,
  input logic cnt_zero,
  input logic load_ev,
  input logic rst_req
);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r7_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(tick && cnt_zero && !load_ev));

  a_r8_stays_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!rst_req && !tick));

  a_r6_pre_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wr |=> pvu);

  a_r6_rld_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rld_wr |=> rvu);

  a_r5_locked_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !pvu) |=> !pvu);

  a_r5_locked_rld: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !rvu) |=> !rvu);

endmodule

bind kwdg_top kwdg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .running(running_w), .unlocked(unlocked_w),
  .pvu(pvu), .rvu(rvu), .pre_wr(pre_wr), .rld_wr(rld_wr), .tick(tick_w),
  .cnt_zero(cnt_zero), .load_ev(load_ev), .rst_req(rst_req)
);

// File: tb/sim_kwdg_top.sv
module sim_kwdg_top;

  localparam logic [4:0] A_KEY = 5'h00, A_PRE = 5'h04, A_RLD = 5'h08,
                         A_STS = 5'h0C, A_WIN = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kwdg_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Cycles from the last write edge to the cycle in which rst_req is seen.
  task automatic meas(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      n++;
      if (rst_req) break;
    end
  endtask

  task automatic cfg(input int np, input int r);
    wr(A_KEY, 16'h5555);
    wr(A_PRE, 16'(np));
    wr(A_RLD, 16'(r));
    repeat (6) @(posedge clk);
    #1;
    wr(A_KEY, 16'h0000);
  endtask

  function automatic int expect_to(input int np, input int r);
    int e;
    e = (np > 8) ? 8 : np;
    return (r + 1) * (4 << e);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n, hi;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rst_req", rst_req, 0);
    rd(A_STS, d); chk("R1 status", d, 0);
    rd(A_PRE, d); chk("R1 divider", d, 0);
    rd(A_RLD, d); chk("R1 reload", d, 16'hFFF);
    // R10 zero reads
    rd(A_KEY, d); chk("R10 key read", d, 0);
    rd(A_WIN, d); chk("R10 window read", d, 0);

    // R5 locked after reset
    wr(A_RLD, 16'd5);
    rd(A_STS, d); chk("R5 locked status", d, 0);
    rd(A_RLD, d); chk("R5 locked reload", d, 16'hFFF);
    // R9 unknown key does not unlock
    wr(A_KEY, 16'h1234);
    wr(A_PRE, 16'd3);
    rd(A_PRE, d); chk("R9 bogus key no unlock", d, 0);
    // R9 unknown key does not lock
    wr(A_KEY, 16'h5555);
    wr(A_KEY, 16'hABCD);
    wr(A_RLD, 16'd2);
    // R6 reload flag held 4 cycles
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      rd(A_STS, d);
      if (d[1]) hi++; else break;
      @(posedge clk); #1;
    end
    chk("R6 reload flag cycles", hi, 4);
    rd(A_RLD, d); chk("R9 bogus key no lock", d, 2);
    wr(A_PRE, 16'd0);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      rd(A_STS, d);
      if (d[0]) hi++; else break;
      @(posedge clk); #1;
    end
    chk("R6 divider flag cycles", hi, 4);
    wr(A_KEY, 16'h0000);
    wr(A_PRE, 16'd7);
    rd(A_PRE, d); chk("R5 relock divider", d, 0);
    rd(A_STS, d); chk("R5 relock status", d, 0);

    // R2 idle: no request before start
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (rst_req) hi++;
    end
    chk("R2 idle no request", hi, 0);
    wr(A_KEY, 16'hCCCC);
    meas(n); chk("R2 start timeout", n, 12);
    @(posedge clk); #1; chk("R7 single cycle", rst_req, 0);
    meas(n); chk("R7 repeat period", n, 11);

    // R8 cannot be stopped
    wr(A_KEY, 16'h0000);
    wr(A_KEY, 16'h1234);
    wr(A_KEY, 16'h5555);
    wr(A_KEY, 16'h0000);
    meas(n); chk("R8 still running", (n <= 12) ? 1 : 0, 1);

    // R4 refresh restarts the full timeout
    repeat (8) @(posedge clk);
    wr(A_KEY, 16'hAAAA);
    meas(n); chk("R4 refresh timeout", n, 12);

    // R3 sweep over divider fields and two reload values
    for (int np = 0; np <= 10; np++) begin
      for (int k = 0; k < 2; k++) begin
        int r, fld;
        r = (k == 0) ? 2 : 5;
        fld = (np == 10) ? 15 : np;
        cfg(fld, r);
        rd(A_PRE, d); chk("R3 divider readback", d, fld);
        wr(A_KEY, 16'hAAAA);
        meas(n);
        chk($sformatf("R3 timeout N=%0d R=%0d", fld, r), n, expect_to(fld, r));
      end
    end

    // R9 unknown key while running does not refresh
    cfg(1, 2);
    wr(A_KEY, 16'hAAAA);
    repeat (5) @(posedge clk);
    wr(A_KEY, 16'hABAB);
    meas(n); chk("R9 bogus key no refresh", 6 + n, 24);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule